// File: doc/BRIEF.md
# Associative Page Translation Buffer

This block keeps the eight most useful virtual-to-physical page translations close to the address path, so that most operand and instruction references skip the segment and page table reads. A lookup presents a virtual page tag. One cycle later the block answers with a hit and the physical page frame, or with a miss. On a miss an external table walker fetches the translation and offers it back as a fill. The fill is then placed by a recent-usage replacement rule.

Each entry carries a valid bit, a recent-usage bit and a lock bit that keeps the entry out of replacement. A write to the segment table base register invalidates the whole buffer. A separate fetch page register holds the last translated instruction page. Sequential instruction fetches that stay in that page are answered from it without consulting the array. The tag is 20 bits wide in wide-address mode. In narrow mode only its low 12 bits take part.

Top module: `atb_top`

## Requirements
- R1: After reset every entry is invalid, the fetch page register is empty and `hitOut`, `missOut` and `frameOut` are 0. A first lookup therefore misses.
- R2: A lookup requested in cycle t is answered after the next clock edge. A hit gives `hitOut`=1 and `missOut`=0 with the stored frame on `frameOut`. A miss gives `missOut`=1 and `hitOut`=0 with `frameOut`=0. With no request, both flags are 0.
- R3: With `wideMode`=0, tag bits [19:12] are forced to zero, both on the stored fill tag and on the lookup tag. With `wideMode`=1, all 20 tag bits are compared.
- R4: A fill is written into the lowest-numbered entry whose usage bit is 0 and whose lock bit is 0. That entry becomes valid with its usage bit set. At most one entry is loaded per cycle.
- R5: An array hit sets the usage bit of the entry that hit. A usage bit is never 1 on an invalid entry.
- R6: When the usage bits from hits and from a fill in the same cycle would make all eight bits 1, all eight are cleared instead.
- R7: A `segTableWrite` pulse clears every valid bit, every usage bit and the fetch page register. A fill in the same cycle is discarded. A lookup in the same cycle is answered from the state before the pulse.
- R8: `lockWrite` sets the lock bit of entry `lockIdx` to `lockSet`. A locked entry is never chosen for a fill, but its stored translation still hits.
- R9: If no entry is eligible for a fill, the fill is dropped and the buffer is unchanged.
- R10: A lookup with `fetchReq`=1 and `seqFetch`=1 whose tag equals the fetch page register is answered from that register. It does not change any usage bit. Any other fetch lookup goes to the array, and an array hit reloads the register. Replacing an array entry does not touch the register.
- R11: A lookup and a fill in the same cycle: the lookup sees the buffer as it was before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupTag | input | 20 | Virtual page tag to translate |
| fetchReq | input | 1 | Lookup is an instruction fetch |
| seqFetch | input | 1 | Fetch is sequential (no branch) |
| wideMode | input | 1 | 1: 20-bit tag, 0: low 12 tag bits only |
| fillValid | input | 1 | Walker delivers a translation |
| fillTag | input | 20 | Tag of the delivered translation |
| fillFrame | input | 12 | Physical page frame of the delivered translation |
| segTableWrite | input | 1 | Segment table base register written; flush |
| lockWrite | input | 1 | Update one entry's lock bit |
| lockIdx | input | 3 | Entry whose lock bit is written |
| lockSet | input | 1 | New lock bit value |
| hitOut | output | 1 | Registered hit for the previous request |
| missOut | output | 1 | Registered miss for the previous request |
| frameOut | output | 12 | Registered frame on a hit, else 0 |

## Verification
A hit and a fill can land in the same cycle. When they do, the usage bit from the hit and the one from the fill merge, and the merge can complete the set of eight and trigger the clear. The bench provokes this on purpose: seven entries carry usage bits, then a lookup of a resident page is issued together with a fill. The clear is judged by where the following fills land, read back through later lookups that hit or miss against a bench model. Random traffic mixes lookups with fills, flushes and lock changes, and lands such pairs many more times.

// File: rtl/atb_pkg.sv
package atb_pkg;
  localparam int ATB_ENTRIES = 8;
  localparam int ATB_IDX_W = $clog2(ATB_ENTRIES);

  typedef struct packed {
    logic [ATB_ENTRIES-1:0] entryWrite;
    logic                   iprLoad;
    logic                   iprClear;
    logic                   respHit;
    logic                   respFromIpr;
    logic [ATB_IDX_W-1:0]   respIdx;
  } atbStrobes_t;
endpackage

// File: rtl/atb_ctrl.sv
module atb_ctrl
  import atb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic                   fetchReq,
  input  logic                   seqFetch,
  input  logic                   fillValid,
  input  logic                   segTableWrite,
  input  logic                   lockWrite,
  input  logic [ATB_IDX_W-1:0]   lockIdx,
  input  logic                   lockSet,
  input  logic [ATB_ENTRIES-1:0] tagMatch,
  input  logic                   iprMatch,
  output atbStrobes_t            strobes,
  output logic                   hitOut,
  output logic                   missOut
);
  localparam int E = ATB_ENTRIES;

  logic [E-1:0] validBits, usageBits, lockBits;
  logic [E-1:0] hitVec, hitOh, eligVec, victimOh, fillOh;
  logic [E-1:0] usageMerged, usageNext, validNext;
  logic [ATB_IDX_W-1:0] hitIdx;
  logic useIpr, arrayLookup, anyHit, arrayHit, doFill;

  function automatic logic [E-1:0] lowestOne(input logic [E-1:0] v);
    logic [E-1:0] res;
    res = '0;
    for (int i = E - 1; i >= 0; i--) begin
      if (v[i]) begin
        res = '0;
        res[i] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [ATB_IDX_W-1:0] indexOf(input logic [E-1:0] oh);
    logic [ATB_IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < E; i++) begin
      if (oh[i]) idx = ATB_IDX_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    useIpr      = lookupValid && fetchReq && seqFetch && iprMatch;
    arrayLookup = lookupValid && !useIpr;
    hitVec      = tagMatch & validBits;
    anyHit      = |hitVec;
    arrayHit    = arrayLookup && anyHit;
    hitOh       = lowestOne(hitVec);
    hitIdx      = indexOf(hitOh);
    eligVec     = ~usageBits & ~lockBits;
    victimOh    = lowestOne(eligVec);
    doFill      = fillValid && !segTableWrite && (|eligVec);
    fillOh      = doFill ? victimOh : '0;
    usageMerged = usageBits | (arrayHit ? hitOh : '0) | fillOh;
    if (segTableWrite || (&usageMerged)) usageNext = '0;
    else usageNext = usageMerged;
    validNext   = segTableWrite ? '0 : (validBits | fillOh);
  end

  always_comb begin
    strobes.entryWrite  = fillOh;
    strobes.iprLoad     = arrayHit && fetchReq && !segTableWrite;
    strobes.iprClear    = segTableWrite;
    strobes.respHit     = useIpr || arrayHit;
    strobes.respFromIpr = useIpr;
    strobes.respIdx     = hitIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      usageBits <= '0;
      lockBits  <= '0;
      hitOut    <= 1'b0;
      missOut   <= 1'b0;
    end else begin
      validBits <= validNext;
      usageBits <= usageNext;
      if (lockWrite) lockBits[lockIdx] <= lockSet;
      hitOut    <= useIpr || arrayHit;
      missOut   <= arrayLookup && !anyHit;
    end
  end
endmodule

// File: rtl/atb_datapath.sv
module atb_datapath
  import atb_pkg::*;
#(
  parameter int VTAG_W   = 20,
  parameter int NARROW_W = 12,
  parameter int FRAME_W  = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [VTAG_W-1:0]      lookupTag,
  input  logic [VTAG_W-1:0]      fillTag,
  input  logic [FRAME_W-1:0]     fillFrame,
  input  logic                   wideMode,
  input  atbStrobes_t            strobes,
  output logic [ATB_ENTRIES-1:0] tagMatch,
  output logic                   iprMatch,
  output logic [FRAME_W-1:0]     frameOut
);
  localparam int E = ATB_ENTRIES;
  localparam logic [VTAG_W-1:0] NARROW_MASK =
    {{(VTAG_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [VTAG_W-1:0]  tagArr   [E];
  logic [FRAME_W-1:0] frameArr [E];
  logic [VTAG_W-1:0]  lookupEff, fillEff, iprTag;
  logic [FRAME_W-1:0] iprFrame, selFrame;
  logic               iprValid;

  assign lookupEff = wideMode ? lookupTag : (lookupTag & NARROW_MASK);
  assign fillEff   = wideMode ? fillTag : (fillTag & NARROW_MASK);
  assign selFrame  = frameArr[strobes.respIdx];
  assign iprMatch  = iprValid && (iprTag == lookupEff);

  for (genvar g = 0; g < E; g++) begin : g_cmp
    assign tagMatch[g] = (tagArr[g] == lookupEff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < E; i++) begin
        tagArr[i]   <= '0;
        frameArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < E; i++) begin
        if (strobes.entryWrite[i]) begin
          tagArr[i]   <= fillEff;
          frameArr[i] <= fillFrame;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iprValid <= 1'b0;
      iprTag   <= '0;
      iprFrame <= '0;
      frameOut <= '0;
    end else begin
      if (strobes.iprClear) begin
        iprValid <= 1'b0;
      end else if (strobes.iprLoad) begin
        iprValid <= 1'b1;
        iprTag   <= lookupEff;
        iprFrame <= selFrame;
      end
      if (strobes.respHit) frameOut <= strobes.respFromIpr ? iprFrame : selFrame;
      else frameOut <= '0;
    end
  end
endmodule

// File: rtl/atb_top.sv
module atb_top
  import atb_pkg::*;
#(
  parameter int VTAG_W   = 20,
  parameter int NARROW_W = 12,
  parameter int FRAME_W  = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lookupValid,
  input  logic [VTAG_W-1:0]    lookupTag,
  input  logic                 fetchReq,
  input  logic                 seqFetch,
  input  logic                 wideMode,
  input  logic                 fillValid,
  input  logic [VTAG_W-1:0]    fillTag,
  input  logic [FRAME_W-1:0]   fillFrame,
  input  logic                 segTableWrite,
  input  logic                 lockWrite,
  input  logic [ATB_IDX_W-1:0] lockIdx,
  input  logic                 lockSet,
  output logic                 hitOut,
  output logic                 missOut,
  output logic [FRAME_W-1:0]   frameOut
);
  atbStrobes_t            strobes;
  logic [ATB_ENTRIES-1:0] tagMatch;
  logic                   iprMatch;

  atb_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .fetchReq(fetchReq),
    .seqFetch(seqFetch), .fillValid(fillValid), .segTableWrite(segTableWrite),
    .lockWrite(lockWrite), .lockIdx(lockIdx), .lockSet(lockSet),
    .tagMatch(tagMatch), .iprMatch(iprMatch), .strobes(strobes),
    .hitOut(hitOut), .missOut(missOut)
  );

  atb_datapath #(.VTAG_W(VTAG_W), .NARROW_W(NARROW_W), .FRAME_W(FRAME_W)) dpInst (
    .clk(clk), .rstN(rstN), .lookupTag(lookupTag), .fillTag(fillTag),
    .fillFrame(fillFrame), .wideMode(wideMode), .strobes(strobes),
    .tagMatch(tagMatch), .iprMatch(iprMatch), .frameOut(frameOut)
  );
endmodule

// File: rtl/atb_checker.sv
module atb_checker
  import atb_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   lookupValid,
  input logic                   segTableWrite,
  input logic                   hitOut,
  input logic                   missOut,
  input logic [ATB_ENTRIES-1:0] validBits,
  input logic [ATB_ENTRIES-1:0] usageBits,
  input logic [ATB_ENTRIES-1:0] lockBits
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(hitOut && missOut));

  p_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (hitOut || missOut));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !(hitOut || missOut));

  p_single_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(validBits & ~$past(validBits)));

  p_usage_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (usageBits & ~validBits) == '0);

  p_never_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    usageBits != '1);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rstN)
    segTableWrite |=> (validBits == '0 && usageBits == '0));

  p_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (validBits & ~$past(validBits) & $past(lockBits)) == '0);
endmodule

bind atb_top atb_checker chkInst (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
  .segTableWrite(segTableWrite), .hitOut(hitOut), .missOut(missOut),
  .validBits(ctrlInst.validBits), .usageBits(ctrlInst.usageBits),
  .lockBits(ctrlInst.lockBits)
);

// File: tb/atb_top_tb.sv
`timescale 1ns/1ps
module atb_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 0, fetchReq = 0, seqFetch = 0, wideMode = 1;
  logic [19:0] lookupTag = '0, fillTag = '0;
  logic [11:0] fillFrame = '0;
  logic        fillValid = 0, segTableWrite = 0, lockWrite = 0, lockSet = 0;
  logic [2:0]  lockIdx = '0;
  logic        hitOut, missOut;
  logic [11:0] frameOut;

  int checks = 0;
  int fails = 0;

  logic [19:0] mTag [8];
  logic [11:0] mFrame [8];
  bit          mValid [8];
  bit          mUse [8];
  bit          mLock [8];
  bit          mIprV;
  logic [19:0] mIprTag;
  logic [11:0] mIprFrame;

  always #4 clk = ~clk;

  atb_top dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupTag(lookupTag),
    .fetchReq(fetchReq), .seqFetch(seqFetch), .wideMode(wideMode),
    .fillValid(fillValid), .fillTag(fillTag), .fillFrame(fillFrame),
    .segTableWrite(segTableWrite), .lockWrite(lockWrite), .lockIdx(lockIdx),
    .lockSet(lockSet), .hitOut(hitOut), .missOut(missOut), .frameOut(frameOut)
  );

  function automatic logic [19:0] effTag(input logic [19:0] t, input bit wide);
    return wide ? t : {8'h00, t[11:0]};
  endfunction

  function automatic bit resident(input logic [19:0] e);
    for (int i = 0; i < 8; i++) if (mValid[i] && mTag[i] == e) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [19:0] poolTag(input int k);
    logic [3:0] kk;
    kk = 4'(k);
    return {6'h00, kk[3:2], 4'h1, 6'h00, kk[1:0]};
  endfunction

  task automatic step(input bit look, input bit fetch, input bit seq,
                      input logic [19:0] tag, input bit wide,
                      input bit fill, input logic [19:0] ftag, input logic [11:0] fframe,
                      input bit flush, input bit lk, input int lkIdx, input bit lkSet,
                      input string lab);
    logic [19:0] e, fe;
    bit useIpr, arrLook, eHit, eMiss, allSet;
    logic [11:0] eFrame;
    int hi, vi;
    lookupValid = look; fetchReq = fetch; seqFetch = seq; lookupTag = tag;
    wideMode = wide; fillValid = fill; fillTag = ftag; fillFrame = fframe;
    segTableWrite = flush; lockWrite = lk; lockIdx = 3'(lkIdx); lockSet = lkSet;
    e = effTag(tag, wide);
    fe = effTag(ftag, wide);
    useIpr = look && fetch && seq && mIprV && (mIprTag == e);
    arrLook = look && !useIpr;
    hi = -1;
    for (int i = 0; i < 8; i++) if (hi < 0 && mValid[i] && mTag[i] == e) hi = i;
    eHit = useIpr || (arrLook && hi >= 0);
    eMiss = arrLook && hi < 0;
    eFrame = useIpr ? mIprFrame : ((arrLook && hi >= 0) ? mFrame[hi] : 12'h000);
    vi = -1;
    for (int i = 0; i < 8; i++) if (vi < 0 && !mUse[i] && !mLock[i]) vi = i;
    if (arrLook && hi >= 0) begin
      mUse[hi] = 1;
      if (fetch && !flush) begin
        mIprV = 1; mIprTag = e; mIprFrame = mFrame[hi];
      end
    end
    if (fill && !flush && vi >= 0) begin
      mTag[vi] = fe; mFrame[vi] = fframe; mValid[vi] = 1; mUse[vi] = 1;
    end
    allSet = 1;
    for (int i = 0; i < 8; i++) allSet &= mUse[i];
    if (allSet) for (int i = 0; i < 8; i++) mUse[i] = 0;
    if (flush) begin
      for (int i = 0; i < 8; i++) begin mValid[i] = 0; mUse[i] = 0; end
      mIprV = 0;
    end
    if (lk) mLock[lkIdx] = lkSet;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (hitOut !== eHit || missOut !== eMiss || frameOut !== eFrame) begin
      fails++;
      $display("FAIL %s: hit=%0b miss=%0b frame=%h expected hit=%0b miss=%0b frame=%h",
               lab, hitOut, missOut, frameOut, eHit, eMiss, eFrame);
    end
  endtask

  task automatic lookOnly(input logic [19:0] t, input string lab);
    step(1, 0, 0, t, 1, 0, '0, '0, 0, 0, 0, 0, lab);
  endtask

  task automatic fillOnly(input logic [19:0] t, input logic [11:0] f, input string lab);
    step(0, 0, 0, '0, 1, 1, t, f, 0, 0, 0, 0, lab);
  endtask

  task automatic fetchLook(input logic [19:0] t, input bit seq, input string lab);
    step(1, 1, seq, t, 1, 0, '0, '0, 0, 0, 0, 0, lab);
  endtask

  task automatic flushAll(input string lab);
    step(0, 0, 0, '0, 1, 0, '0, '0, 1, 0, 0, 0, lab);
  endtask

  task automatic setLock(input int idx, input bit v, input string lab);
    step(0, 0, 0, '0, 1, 0, '0, '0, 0, 1, idx, v, lab);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 8; i++) begin
      mValid[i] = 0; mUse[i] = 0; mLock[i] = 0; mTag[i] = '0; mFrame[i] = '0;
    end
    mIprV = 0; mIprTag = '0; mIprFrame = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: idle outputs after reset, first lookup misses
    step(0, 0, 0, '0, 1, 0, '0, '0, 0, 0, 0, 0, "R1 reset idle");
    lookOnly(20'h00123, "R1 first lookup");

    // R4 / R2: basic fills and hits
    fillOnly(20'h0A001, 12'h101, "R4");
    fillOnly(20'h0B002, 12'h102, "R4");
    fillOnly(20'h0C003, 12'h103, "R4");
    lookOnly(20'h0A001, "R2 hit A");
    lookOnly(20'h0B002, "R2 hit B");
    lookOnly(20'h0C003, "R2 hit C");

    // R11: same-cycle lookup and fill of the same page
    step(1, 0, 0, 20'h0D004, 1, 1, 20'h0D004, 12'h104, 0, 0, 0, 0, "R11 same cycle");
    lookOnly(20'h0D004, "R11 after fill");

    // R6: hit plus fill completes the usage set
    fillOnly(20'h0E005, 12'h105, "R4");
    fillOnly(20'h0F006, 12'h106, "R4");
    fillOnly(20'h10007, 12'h107, "R4");
    step(1, 0, 0, 20'h0A001, 1, 1, 20'h11008, 12'h108, 0, 0, 0, 0, "R6 hit+fill");
    fillOnly(20'h12009, 12'h109, "R6");
    lookOnly(20'h0A001, "R6 entry0 replaced");
    lookOnly(20'h0B002, "R5 hit sets usage");
    fillOnly(20'h1300A, 12'h10A, "R5");
    lookOnly(20'h0C003, "R5 victim skips used");
    lookOnly(20'h0B002, "R5 used entry kept");
    lookOnly(20'h1300A, "R4 new entry");

    // R3: narrow mode masking
    step(0, 0, 0, '0, 0, 1, 20'hABCDE, 12'h3CD, 0, 0, 0, 0, "R3 narrow fill");
    step(1, 0, 0, 20'h11CDE, 0, 0, '0, '0, 0, 0, 0, 0, "R3 narrow hit");
    step(1, 0, 0, 20'h11CDE, 1, 0, '0, '0, 0, 0, 0, 0, "R3 wide miss");

    // R7: flush
    step(1, 0, 0, 20'h0B002, 1, 1, 20'h1400B, 12'h10B, 1, 0, 0, 0, "R7 flush cycle");
    lookOnly(20'h0B002, "R7 after flush");
    lookOnly(20'h1400B, "R7 fill discarded");

    // R8 / R9: lock bits
    setLock(0, 1, "R8");
    setLock(1, 1, "R8");
    fillOnly(20'h1500C, 12'h10C, "R8");
    for (int i = 3; i < 8; i++) setLock(i, 1, "R8");
    setLock(2, 1, "R8");
    fillOnly(20'h1600D, 12'h10D, "R9");
    lookOnly(20'h1600D, "R9 dropped fill");
    lookOnly(20'h1500C, "R8 locked still hits");
    for (int i = 0; i < 8; i++) setLock(i, 0, "R8");

    // R10: fetch page register
    flushAll("R10");
    fillOnly(20'h20001, 12'h201, "R10");
    fetchLook(20'h20001, 0, "R10 branch fetch");
    for (int i = 1; i < 8; i++) fillOnly(20'h20001 + 20'(i * 16), 12'(12'h201 + i), "R10");
    fetchLook(20'h20001, 1, "R10 seq from register");
    fillOnly(20'h2F00F, 12'h2FF, "R10");
    lookOnly(20'h20001, "R10 entry0 replaced");
    fetchLook(20'h20001, 1, "R10 register intact");
    fetchLook(20'h2F00F, 1, "R10 page change");
    fetchLook(20'h20001, 1, "R10 old page gone");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      bit look, fetch, seq, wide, fill, flush, lk, lkSet;
      logic [19:0] t, ft;
      int lkIdx;
      look  = ($urandom % 10) < 7;
      fetch = ($urandom % 2) == 1;
      seq   = ($urandom % 2) == 1;
      wide  = ($urandom % 10) < 8;
      t     = poolTag(int'($urandom % 16));
      ft    = poolTag(int'($urandom % 16));
      fill  = (($urandom % 10) < 3) && !resident(effTag(ft, wide));
      flush = ($urandom % 50) == 0;
      lk    = ($urandom % 30) == 0;
      lkIdx = int'($urandom % 8);
      lkSet = ($urandom % 3) == 0;
      step(look, fetch, seq, t, wide, fill, ft, 12'($urandom), flush, lk, lkIdx, lkSet,
           "R2 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule